// File: doc/BRIEF.md
# Hour Strike Controller

This block strikes the hour on a chiming clock. When the sequencer that plays the full top-of-hour melody finishes, it sends one start pulse. The controller then sounds a number of strikes equal to the current 12-hour time. Each strike raises two low-pitch tone gates together for a fixed fraction of the strike interval. The strike interval comes from a rate setting. The audio path turns the gates into sound. Generating that audio is not part of this block.

On an accepted start, the block captures the hour, given as two BCD digits, and the rate value. A strike tally counts up in BCD from 1. After each strike interval the tally is compared on both digits against the captured hour. A match ends the sequence and clears the busy latch. Because the hour is captured at start, the hour input can roll over while striking without changing the number of strikes.

Top module: `hour_strike_ctrl`

## Requirements
- R1: While reset is held and after its release with no start, `busy_o`, `gate_lo_o` and `gate_hi_o` are all 0.
- R2: A start pulse sampled while idle with a valid hour sets `busy_o` and raises both gates in the very next cycle, so the first strike has no delay.
- R3: `gate_lo_o` and `gate_hi_o` are equal in every cycle, and neither is high while `busy_o` is 0.
- R4: One strike begins every I = (rate+1)·2^TICK_LOG2 cycles. The rate is sampled at start, and later changes to `rate_i` during striking have no effect.
- R5: In each strike interval, both gates are high for the first P = I/4 = (rate+1)·2^(TICK_LOG2−2) cycles and low for the rest.
- R6: The number of strikes equals the hour value H = 10·tens + ones. The tally counts in BCD (09 is followed by 10) and is compared on both digits. `busy_o` stays high for exactly H·I cycles and then returns to 0.
- R7: Changes on `hour_tens_i` and `hour_ones_i` after start do not change the number of strikes.
- R8: A start pulse that arrives while `busy_o` is 1 is ignored. The sequence in progress keeps its timing and its count.
- R9: A start pulse with an hour outside 01..12 is ignored and `busy_o` stays 0. This covers 00, 13 and above, and any digit that is not valid BCD (tens > 1 or ones > 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse from the melody sequencer |
| hour_tens_i | input | 4 | BCD tens digit of the current hour |
| hour_ones_i | input | 4 | BCD ones digit of the current hour |
| rate_i | input | RATE_W | Strike rate setting; interval is (rate_i+1)·2^TICK_LOG2 cycles |
| gate_lo_o | output | 1 | Tone gate for the lowest pitch |
| gate_hi_o | output | 1 | Tone gate for the second pitch |
| busy_o | output | 1 | High while a strike sequence runs |

## Verification
Every output is registered once after the start edge. The bench raises `start_i` on a falling edge, and the first expected item is due one cycle later, just after the next rising edge. From there, every following cycle has its own expected busy and gate value. Strike k begins at offset k·I. Its gate window covers offsets 0..P−1 inside that interval, and `busy_o` falls exactly H·I cycles after the start edge. The driver queues one expected item per cycle, plus trailing idle cycles. The monitor pops one item 1 ns after each rising edge. This keeps every comparison locked to the cycle count worked out from the requirements.

// File: rtl/hstrike_pkg.sv
package hstrike_pkg;

  // Next value of a two-digit BCD tally.
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // True when the BCD pair is an hour of a 12-hour clock (01..12).
  function automatic logic hour_ok(input logic [7:0] v);
    logic lo_ok;
    logic hi_ok;
    lo_ok = (v[7:4] == 4'd0) && (v[3:0] != 4'd0) && (v[3:0] <= 4'd9);
    hi_ok = (v[7:4] == 4'd1) && (v[3:0] <= 4'd2);
    return lo_ok || hi_ok;
  endfunction

endpackage

// File: rtl/hstrike_timer.sv
module hstrike_timer #(
  parameter int RATE_W    = 6,
  parameter int TICK_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              phase_end_o,
  output logic              pulse_o
);

  localparam int PH_W  = RATE_W + TICK_LOG2;
  localparam int SUB   = TICK_LOG2 - 2;
  localparam int CMP_W = PH_W - SUB;

  logic [RATE_W-1:0] rate_q;
  logic [PH_W-1:0]   phase_q;
  logic [PH_W-1:0]   last_w;

  // Last phase of an interval: (rate+1)*2^TICK_LOG2 - 1.
  function automatic logic [PH_W-1:0] last_phase(input logic [RATE_W-1:0] r);
    return {r, {TICK_LOG2{1'b1}}};
  endfunction

  // Gate window: the first quarter of the interval.
  function automatic logic in_window(input logic [PH_W-1:0] ph,
                                     input logic [RATE_W-1:0] r);
    logic [CMP_W-1:0] coarse;
    coarse = CMP_W'(ph >> SUB);
    return coarse <= CMP_W'(r);
  endfunction

  assign last_w      = last_phase(rate_q);
  assign phase_end_o = run_i && (phase_q == last_w);
  assign pulse_o     = run_i && in_window(phase_q, rate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      phase_q <= '0;
    end else if (load_i) begin
      rate_q  <= rate_i;
      phase_q <= '0;
    end else if (run_i) begin
      phase_q <= phase_end_o ? '0 : phase_q + 1'b1;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (phase_q <= last_w)); // R4

  AST_NEXT_STRIKE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end_o && !load_i) |=> (!run_i || pulse_o)); // R4

  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i) |=> $stable(rate_q)); // R4

endmodule

// File: rtl/hstrike_tally.sv
module hstrike_tally
  import hstrike_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] hour_i,
  input  logic       step_i,
  output logic [7:0] count_o,
  output logic       last_o
);

  logic [7:0] count_q;
  logic [7:0] target_q;

  assign count_o = count_q;
  assign last_o  = (count_q == target_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= 8'h00;
      target_q <= 8'h00;
    end else if (load_i) begin
      count_q  <= 8'h01;
      target_q <= hour_i;
    end else if (step_i) begin
      count_q  <= bcd_step(count_q);
    end
  end

  AST_COUNT_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (count_q[3:0] <= 4'd9)); // R6

  AST_NO_PASS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !last_o); // R6

  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(target_q)); // R7

endmodule

// File: rtl/hour_strike_ctrl.sv
module hour_strike_ctrl
  import hstrike_pkg::*;
#(
  parameter int RATE_W    = 6,
  parameter int TICK_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        hour_tens_i,
  input  logic [3:0]        hour_ones_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              gate_lo_o,
  output logic              gate_hi_o,
  output logic              busy_o
);

  logic [7:0] hour_w;
  logic       hour_ok_w;
  logic       accept_w;
  logic       phase_end_w;
  logic       pulse_w;
  logic       last_w;
  logic       step_w;
  logic       done_w;
  logic [7:0] count_w;
  logic       busy_q;

  assign hour_w    = {hour_tens_i, hour_ones_i};
  assign hour_ok_w = hour_ok(hour_w);
  assign accept_w  = start_i && !busy_q && hour_ok_w;
  assign step_w    = phase_end_w && !last_w;
  assign done_w    = phase_end_w && last_w;

  hstrike_timer #(
    .RATE_W    (RATE_W),
    .TICK_LOG2 (TICK_LOG2)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept_w),
    .run_i       (busy_q),
    .rate_i      (rate_i),
    .phase_end_o (phase_end_w),
    .pulse_o     (pulse_w)
  );

  hstrike_tally u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_w),
    .hour_i  (hour_w),
    .step_i  (step_w),
    .count_o (count_w),
    .last_o  (last_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_q <= 1'b0;
    else if (accept_w) busy_q <= 1'b1;
    else if (done_w)   busy_q <= 1'b0;
  end

  assign busy_o    = busy_q;
  assign gate_lo_o = pulse_w;
  assign gate_hi_o = pulse_w;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !pulse_w); // R3

  AST_FIRST_STRIKE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (busy_q && pulse_w)); // R2

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_w) |=> busy_q); // R8

  AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_end_w && !last_w) |=> busy_q); // R6

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (count_w >= 8'h01 && count_w <= 8'h12)); // R6

  AST_REJECT_BAD_HOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start_i && !hour_ok_w) |=> !busy_q); // R9

endmodule

// File: tb/hour_strike_ctrl_tb.sv
module hour_strike_ctrl_tb;

  localparam int RATE_W = 6;

  typedef struct packed {
    logic       busy;
    logic       gate;
    logic [3:0] tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [3:0]        hour_tens_i = 4'd0;
  logic [3:0]        hour_ones_i = 4'd0;
  logic [RATE_W-1:0] rate_i = '0;
  logic              gate_lo_o;
  logic              gate_hi_o;
  logic              busy_o;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  hour_strike_ctrl #(.RATE_W(RATE_W), .TICK_LOG2(2)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .hour_tens_i (hour_tens_i),
    .hour_ones_i (hour_ones_i),
    .rate_i      (rate_i),
    .gate_lo_o   (gate_lo_o),
    .gate_hi_o   (gate_hi_o),
    .busy_o      (busy_o)
  );

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: one expected item per cycle, sampled 1 ns after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check(tag_name(it.tag), busy_o, it.busy);
        check(it.gate ? tag_name(it.tag) : "R5", gate_lo_o, it.gate);
        check("R3", gate_hi_o, gate_lo_o);
      end
    end
  end

  // Driver: starts one sequence and queues the expected cycle-by-cycle outputs.
  // disturb=1 changes the hour and rate inputs and pulses start during striking.
  task automatic strike_run(input logic [3:0] t, input logic [3:0] o,
                            input logic [RATE_W-1:0] r, input bit disturb);
    int n;
    int iv;
    int pw;
    wait (exp_q.size() == 0);
    @(negedge clk);
    hour_tens_i = t;
    hour_ones_i = o;
    rate_i      = r;
    start_i     = 1'b1;
    n  = int'(t) * 10 + int'(o);
    iv = (int'(r) + 1) * 4;
    pw = int'(r) + 1;
    for (int k = 0; k < n * iv; k++) begin
      exp_t it;
      it.busy = 1'b1;
      it.gate = ((k % iv) < pw);
      if (k == 0)                    it.tag = 4'd2;
      else if (disturb)              it.tag = 4'd8;
      else if ((k % iv) == 0)        it.tag = 4'd4;
      else                           it.tag = 4'd6;
      exp_q.push_back(it);
    end
    for (int k = 0; k < 3; k++) exp_q.push_back(exp_t'{1'b0, 1'b0, disturb ? 4'd7 : 4'd6});
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      repeat (iv + 1) @(negedge clk);
      hour_tens_i = 4'd0;
      hour_ones_i = 4'd3;
      rate_i      = r + 6'd5;
      start_i     = 1'b1;
      @(negedge clk);
      start_i     = 1'b0;
    end
  endtask

  task automatic bad_start(input logic [3:0] t, input logic [3:0] o);
    wait (exp_q.size() == 0);
    @(negedge clk);
    hour_tens_i = t;
    hour_ones_i = o;
    start_i     = 1'b1;
    for (int k = 0; k < 4; k++) exp_q.push_back(exp_t'{1'b0, 1'b0, 4'd9});
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", busy_o, 1'b0);
    check("R1", gate_lo_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", busy_o, 1'b0);
    check("R1", gate_hi_o, 1'b0);

    strike_run(4'd0, 4'd1, 6'd0, 1'b0);   // one strike, shortest interval
    strike_run(4'd1, 4'd2, 6'd2, 1'b0);   // twelve strikes
    strike_run(4'd1, 4'd0, 6'd1, 1'b0);   // tally passes 09 -> 10
    bad_start(4'd0, 4'd0);
    bad_start(4'd1, 4'd3);
    bad_start(4'd0, 4'd10);
    bad_start(4'd2, 4'd1);
    strike_run(4'd1, 4'd1, 6'd1, 1'b1);   // inputs disturbed while striking
    strike_run(4'd0, 4'd3, 6'd63, 1'b0);  // longest interval
    strike_run(4'd0, 4'd9, 6'd0, 1'b0);

    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule